// File: doc/BRIEF.md
# History-Flag Synchronous FIFO

A first-in first-out buffer on a single clock that holds eight 4-bit items between a producer and a consumer. The write and read positions are 3-bit counters. Occupancy is their difference taken modulo eight. With 3-bit pointers, a difference of zero cannot distinguish an empty buffer from a full one.

To tell the two apart, one registered history bit records whether the buffer was last seen running high (occupancy six or seven) or low (occupancy two or three). A zero difference is read as full when the history says high, and as empty when it says low.

Both sides may raise their request without first looking at the status flags. A request that cannot be served in that cycle is refused and flagged as a retry, and the requester presents the same item again later. The head entry appears on the read data port without a clock of delay.

Top module: `hist_fifo`

## Requirements
- R1: After reset, with both requests low: empty=1, full=0, almost_empty=1, almost_full=0, wr_retry=0, rd_retry=0.
- R2: Items leave in the order they were accepted. While the buffer is not empty, rd_data shows the oldest stored item in the same cycle, without waiting for a clock edge.
- R3: With no reads, exactly eight writes are accepted before full rises. full is 1 in the cycle after the eighth accepted write.
- R4: full and empty are never 1 in the same cycle.
- R5: almost_full is set at a clock edge where occupancy is 6 or 7, and cleared at an edge where occupancy is 2 or 3. At any other occupancy it keeps its value. almost_empty is always its complement.
- R6: A write request while full raises wr_retry in that cycle. The stored contents and the occupancy do not change.
- R7: A read request while empty raises rd_retry in that cycle. The occupancy does not change.
- R8: When both requests are accepted in one cycle (buffer neither empty nor full), one item is stored, one is removed, and the occupancy stays the same.
- R9: When both requests arrive while full, only the read is served, leaving seven items. When both arrive while empty, only the write is served, leaving one item.
- R10: full is 1 exactly when occupancy is eight, and empty is 1 exactly when occupancy is zero.
- R11: The pointers wrap from location 7 to location 0, and ordering is preserved across many laps of the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Producer request to store wr_data |
| wr_data | input | 4 | Item to store |
| rd_en | input | 1 | Consumer request to remove the head item |
| rd_data | output | 4 | Current head item (combinational) |
| full | output | 1 | Eight items held |
| empty | output | 1 | No items held |
| almost_full | output | 1 | History bit: last seen running high |
| almost_empty | output | 1 | Complement of almost_full |
| wr_retry | output | 1 | Write request refused this cycle |
| rd_retry | output | 1 | Read request refused this cycle |

## Verification
The assertions assume that the inputs change only away from the rising edge and are known after reset. They also assume that reset is released with both requests low. The bench meets these conditions by driving every request on the falling edge and releasing reset on a falling edge. It is free to raise requests against a full or empty buffer, because refusal is part of the checked behaviour rather than a forbidden input. Occupancy moves by at most one per cycle under any stimulus, so the history bit can never skip a threshold band. The history assertions rely on this.

// File: rtl/hist_fifo_pkg.sv
`timescale 1ns/1ps
package hist_fifo_pkg;

  // Recorded tendency of the buffer: last seen running low or high.
  typedef enum logic {HIST_LOW = 1'b0, HIST_HIGH = 1'b1} hist_e;

  // Band that the current occupancy falls in.
  typedef enum logic [1:0] {ZONE_HOLD = 2'd0, ZONE_LOW = 2'd1, ZONE_HIGH = 2'd2} zone_e;

  // Classify by the two most significant occupancy bits.
  // 11 -> high band, 01 -> low band, anything else (zero included) -> hold.
  function automatic zone_e zone_of(input logic [1:0] top);
    case (top)
      2'b11:   return ZONE_HIGH;
      2'b01:   return ZONE_LOW;
      default: return ZONE_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/hist_fifo_ptr.sv
`timescale 1ns/1ps
module hist_fifo_ptr #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  // Wraps naturally at the power-of-two boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr + AW'(1);
  end
endmodule

// File: rtl/hist_fifo_mem.sv
`timescale 1ns/1ps
module hist_fifo_mem #(
  parameter int AW = 3,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] slots [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (we && waddr == AW'(e))      q <= wdata;
    end
    assign slots[e] = q;
  end

  // Read port is combinational: the head is visible in the same cycle.
  assign rdata = slots[raddr];
endmodule

// File: rtl/hist_fifo_occ.sv
`timescale 1ns/1ps
module hist_fifo_occ #(
  parameter int AW = 3
) (
  input  logic          [AW-1:0] wptr,
  input  logic          [AW-1:0] rptr,
  output logic          [AW-1:0] occ,
  output logic                   raw_high,
  output logic                   raw_low
);
  import hist_fifo_pkg::*;

  // Two's-complement subtract with the final borrow dropped: modulo 2**AW.
  function automatic logic [AW-1:0] mod_sub(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW:0] t;
    t = {1'b0, a} + {1'b0, ~b} + (AW+1)'(1);
    return t[AW-1:0];
  endfunction

  zone_e zone;

  assign occ      = mod_sub(wptr, rptr);
  assign zone     = zone_of(occ[AW-1 -: 2]);
  assign raw_high = (zone == ZONE_HIGH);
  assign raw_low  = (zone == ZONE_LOW);
endmodule

// File: rtl/hist_fifo_hist.sv
`timescale 1ns/1ps
module hist_fifo_hist (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_high,
  input  logic                  set_low,
  output hist_fifo_pkg::hist_e  state
);
  import hist_fifo_pkg::*;

  // Set/clear flip-flop; raw inputs matter only at the edge, so glitches do not.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= HIST_LOW;
    else if (set_high) state <= HIST_HIGH;
    else if (set_low)  state <= HIST_LOW;
  end
endmodule

// File: rtl/hist_fifo.sv
`timescale 1ns/1ps
module hist_fifo #(
  parameter int AW = 3,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty,
  output logic          almost_full,
  output logic          almost_empty,
  output logic          wr_retry,
  output logic          rd_retry
);
  import hist_fifo_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [AW-1:0] occ;
  logic          raw_high;
  logic          raw_low;
  logic          occ_zero;
  logic          wr_fire;
  logic          rd_fire;
  hist_e         hist;

  hist_fifo_ptr #(.AW(AW)) u_wptr (.clk(clk), .rst_n(rst_n), .adv(wr_fire), .ptr(wptr));
  hist_fifo_ptr #(.AW(AW)) u_rptr (.clk(clk), .rst_n(rst_n), .adv(rd_fire), .ptr(rptr));

  hist_fifo_occ #(.AW(AW)) u_occ (
    .wptr(wptr), .rptr(rptr), .occ(occ), .raw_high(raw_high), .raw_low(raw_low)
  );

  hist_fifo_hist u_hist (
    .clk(clk), .rst_n(rst_n), .set_high(raw_high), .set_low(raw_low), .state(hist)
  );

  hist_fifo_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .waddr(wptr), .wdata(wr_data),
    .raddr(rptr), .rdata(rd_data)
  );

  // A zero difference is resolved by the history bit.
  assign occ_zero     = (occ == '0);
  assign full         = occ_zero && (hist == HIST_HIGH);
  assign empty        = occ_zero && (hist == HIST_LOW);
  assign almost_full  = (hist == HIST_HIGH);
  assign almost_empty = (hist == HIST_LOW);

  // Qualified requests; refused ones are reported for a later retry.
  assign wr_fire  = wr_en && !full;
  assign rd_fire  = rd_en && !empty;
  assign wr_retry = wr_en && full;
  assign rd_retry = rd_en && empty;
endmodule

// File: rtl/hist_fifo_chk.sv
`timescale 1ns/1ps
module hist_fifo_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          full,
  input logic          empty,
  input logic          almost_full,
  input logic          almost_empty,
  input logic          wr_fire,
  input logic          rd_fire,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] rptr,
  input logic [AW-1:0] occ
);
  a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r7_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_fire);

  a_r6_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_fire);

  a_r11_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> wptr == $past(wptr) + AW'(1));

  a_r11_rptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rptr));

  a_r5_set_high: assert property (@(posedge clk) disable iff (!rst_n)
    (occ[AW-1 -: 2] == 2'b11) |=> almost_full);

  a_r5_set_low: assert property (@(posedge clk) disable iff (!rst_n)
    (occ[AW-1 -: 2] == 2'b01) |=> almost_empty);

  a_r8_occ_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_fire) |=> $stable(occ));

  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> full);
endmodule

bind hist_fifo hist_fifo_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .full(full), .empty(empty),
  .almost_full(almost_full), .almost_empty(almost_empty),
  .wr_fire(wr_fire), .rd_fire(rd_fire), .wptr(wptr), .rptr(rptr), .occ(occ)
);

// File: tb/test_hist_fifo.sv
`timescale 1ns/1ps
module test_hist_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = 4'd0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_data;
  logic       full, empty, almost_full, almost_empty, wr_retry, rd_retry;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference model built from the requirements.
  logic [3:0] mq [8];
  int         mhead = 0;
  int         mcount = 0;
  bit         mhigh = 1'b0;
  logic [3:0] seed = 4'd3;

  always #2 clk = ~clk;  // 250 MHz

  hist_fifo i_hist_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .full(full), .empty(empty), .almost_full(almost_full),
    .almost_empty(almost_empty), .wr_retry(wr_retry), .rd_retry(rd_retry)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle: drive on the falling edge, check outputs, then update the model at the rising edge.
  task automatic cyc(input bit we, input logic [3:0] wd, input bit re);
    bit mfull, mempty, wq, rq;
    @(negedge clk);
    wr_en = we; wr_data = wd; rd_en = re;
    #1;
    mfull  = (mcount == 8);
    mempty = (mcount == 0);
    chk("R10 full",         int'(full),         int'(mfull));
    chk("R10 empty",        int'(empty),        int'(mempty));
    chk("R4 not both",      int'(full && empty), 0);
    chk("R5 almost_full",   int'(almost_full),  int'(mhigh));
    chk("R5 almost_empty",  int'(almost_empty), int'(!mhigh));
    chk("R6 wr_retry",      int'(wr_retry),     int'(we && mfull));
    chk("R7 rd_retry",      int'(rd_retry),     int'(re && mempty));
    if (!mempty) chk("R2 head data", int'(rd_data), int'(mq[mhead]));
    wq = we && !mfull;
    rq = re && !mempty;
    @(posedge clk);
    if (mcount == 6 || mcount == 7) mhigh = 1'b1;
    else if (mcount == 2 || mcount == 3) mhigh = 1'b0;
    if (wq) mq[(mhead + mcount) % 8] = wd;
    if (rq) mhead = (mhead + 1) % 8;
    mcount = mcount + int'(wq) - int'(rq);
  endtask

  function automatic logic [3:0] nxt();
    seed = seed * 4'd5 + 4'd7;
    return seed;
  endfunction

  task automatic drain();
    for (int i = 0; i < 9; i++) cyc(1'b0, 4'd0, 1'b1);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 empty",        int'(empty), 1);
    chk("R1 full",         int'(full), 0);
    chk("R1 almost_empty", int'(almost_empty), 1);
    chk("R1 almost_full",  int'(almost_full), 0);
    chk("R1 wr_retry",     int'(wr_retry), 0);
    chk("R1 rd_retry",     int'(rd_retry), 0);
  endtask

  task automatic t_fill_overrun();
    logic [3:0] first;
    first = 4'd0;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] v;
      v = nxt();
      if (i == 0) first = v;
      cyc(1'b1, v, 1'b0);
    end
    #1 chk("R3 full after eighth write", int'(full), 1);
    cyc(1'b1, 4'hF, 1'b0);   // refused
    cyc(1'b1, 4'hE, 1'b0);   // refused
    #1 chk("R6 contents kept", int'(rd_data), int'(first));
    chk("R6 still full", int'(full), 1);
    drain();
    #1 chk("R7 empty after drain", int'(empty), 1);
  endtask

  task automatic t_history();
    for (int i = 0; i < 5; i++) cyc(1'b1, nxt(), 1'b0);
    #1 chk("R5 five held, not high", int'(almost_full), 0);
    for (int i = 0; i < 2; i++) cyc(1'b1, nxt(), 1'b0);
    #1 chk("R5 seven held, high", int'(almost_full), 1);
    for (int i = 0; i < 3; i++) cyc(1'b0, 4'd0, 1'b1);
    #1 chk("R5 four held, high kept", int'(almost_full), 1);
    for (int i = 0; i < 3; i++) cyc(1'b0, 4'd0, 1'b1);
    #1 chk("R5 low band cleared it", int'(almost_empty), 1);
    drain();
  endtask

  task automatic t_simultaneous();
    for (int i = 0; i < 4; i++) cyc(1'b1, nxt(), 1'b0);
    for (int i = 0; i < 6; i++) cyc(1'b1, nxt(), 1'b1);
    #1 chk("R8 count kept at four", mcount, 4);
    chk("R8 not empty", int'(empty), 0);
    drain();
  endtask

  task automatic t_boundary_pairs();
    for (int i = 0; i < 8; i++) cyc(1'b1, nxt(), 1'b0);
    cyc(1'b1, 4'h9, 1'b1);
    #1 chk("R9 full pair leaves seven", int'(full), 0);
    chk("R9 model seven", mcount, 7);
    drain();
    cyc(1'b1, 4'hA, 1'b1);
    #1 chk("R9 empty pair leaves one", int'(empty), 0);
    chk("R9 head is new item", int'(rd_data), 10);
    drain();
  endtask

  task automatic t_wrap();
    for (int lap = 0; lap < 40; lap++) begin
      cyc(1'b1, nxt(), lap % 3 == 0);
      cyc(lap % 2 == 0, nxt(), 1'b1);
    end
    drain();
    #1 chk("R11 empty after many laps", int'(empty), 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cyc(1'b0, 4'd0, 1'b0);
    t_fill_overrun();
    t_history();
    t_simultaneous();
    t_boundary_pairs();
    t_wrap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule